// File: doc/BRIEF.md
# Flow-Controlled Full-Duplex Serial Master

This block is a synchronous serial master that generates its own shift clock and exchanges fixed-width frames with one attached device. Each frame is full duplex. The word loaded into the shifter leaves on `ser_out`, most significant bit first, while the same number of bits arrive on `ser_in`. Once the frame ends, the collected word is placed where the host can read it. The shift clock runs at the system clock divided by `CLK_DIV`.

The host side has a one-entry transmit buffer and a one-entry receive buffer. It sees a transmit-empty flag, a receive-full flag and one-cycle transmit and receive interrupt pulses. The clock only pauses at frame boundaries, and it pauses whenever another frame would lose received data or would have nothing to send. The host therefore never sees an overrun or an underrun.

With `dbl_buf_en` low, the block stops after every frame. It starts again once the host has both read the received word and written a new one, in either order. With `dbl_buf_en` high, a word that is already waiting follows back to back. A word that completes while the receive buffer is still occupied is held internally, and the clock stays stopped until the host catches up.

Top module: `sync_serial_master`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to its idle state. After reset, `tx_empty`=1, `rx_full`=0, `ser_clk`=1, `tx_irq`=0 and `rx_irq`=0.
- R2: `ser_clk` stays high and never falls while no word has been written to the transmit buffer.
- R3: A frame carries DATA_W bits, most significant bit first. Each bit lasts CLK_DIV system cycles: a low half and then a high half. `ser_out` changes only when `ser_clk` falls, and `ser_in` is sampled when `ser_clk` rises. Within a frame, consecutive falling edges are exactly CLK_DIV cycles apart.
- R4: At the end of a frame, the received word appears on `rx_rd_data` with `rx_full`=1, together with a one-cycle `rx_irq` pulse. Received words reach the host in the order they arrived.
- R5: `tx_irq` pulses for exactly one cycle for each completed frame.
- R6: With `dbl_buf_en`=0, the clock stops after every frame. Writing alone does not restart it, and reading alone does not restart it. The next frame starts once both a read and a write have happened, in either order.
- R7: With `dbl_buf_en`=1, suppose a word is waiting in the transmit buffer and the receive buffer is empty when a frame ends. The next frame then starts at once, with its first falling edge exactly CLK_DIV cycles after the previous frame's last falling edge.
- R8: With `dbl_buf_en`=1, `ser_clk` stays high at a frame boundary while the transmit buffer is empty or the receive side is occupied. It resumes only after both conditions clear.
- R9: A word that completes while `rx_full`=1 is held, not dropped or overwritten. It is moved to `rx_rd_data` with an `rx_irq` pulse after the host reads, and the clock stays stopped until it too has been read.
- R10: `tx_empty` goes to 0 in the cycle after a write. It returns to 1 when the word is moved into the shifter, which is one cycle later if the shifter is free.
- R11: Pulsing `rx_rd_en` while `rx_full`=1 clears `rx_full` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbl_buf_en | input | 1 | 1 = back-to-back double buffering, 0 = stop after every frame |
| tx_wr_en | input | 1 | Write strobe for the transmit buffer |
| tx_wr_data | input | DATA_W | Word to transmit |
| rx_rd_en | input | 1 | Read strobe that empties the receive buffer |
| rx_rd_data | output | DATA_W | Received word |
| tx_empty | output | 1 | Transmit buffer is empty |
| rx_full | output | 1 | Receive buffer holds an unread word |
| tx_irq | output | 1 | One-cycle pulse when a frame has been sent |
| rx_irq | output | 1 | One-cycle pulse when a word lands in the receive buffer |
| ser_clk | output | 1 | Shift clock, idles high |
| ser_out | output | 1 | Serial data out |
| ser_in | input | 1 | Serial data in |

## Verification
The bench builds the block with DATA_W=8 and CLK_DIV=4. A frame then takes 32 cycles, so directed stalls, held words and about eighty random back-to-back and stop-start frames all fit in a short run. With CLK_DIV=4 each clock half is two cycles, which exercises the half-period counter's wrap and the bit spacing. A bench-side device model returns a known word per frame and captures what is sent. This checks both data directions and measures the gap at frame joins.

// File: rtl/ssm_pkg.sv
// Shared types for the serial master.
// Assumes nothing beyond a single clock domain.
package ssm_pkg;
    // Phase of the shift engine within a bit period
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } shift_phase_e;
endpackage

// File: rtl/ssm_shift_engine.sv
// Shift engine: generates the divided shift clock and shifts one word out
// (MSB first, launched on the falling edge) while capturing one word in
// (sampled on the rising edge). A frame starts on `start`; at the last
// half-period of a frame a new `start` chains the next frame with no gap.
// Assumes CLK_DIV is even and at least 2, and DATA_W is at least 2.
module ssm_shift_engine
    import ssm_pkg::*;
#(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned CLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] load_word,
    input  logic              ser_in,
    output logic              ser_clk,
    output logic              ser_out,
    output logic [DATA_W-1:0] rx_word,
    output logic              frame_done,
    output logic              busy,
    output logic              tx_irq
);
    localparam int unsigned HALF  = CLK_DIV / 2;
    localparam int unsigned CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int unsigned BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

    shift_phase_e      phase;
    logic [CNT_W-1:0]  cnt;
    logic [BIT_W-1:0]  bit_idx;
    logic [DATA_W-1:0] tx_sr;
    logic [DATA_W-1:0] rx_sr;
    logic              half_end;

    assign half_end   = (cnt == CNT_LAST);
    assign frame_done = (phase == PH_HIGH) && half_end && (bit_idx == BIT_LAST);
    assign busy       = (phase != PH_IDLE);
    assign rx_word    = rx_sr;

    // Phase sequencing, clock generation and both shift registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            tx_sr   <= '0;
            rx_sr   <= '0;
            ser_clk <= 1'b1;
            ser_out <= 1'b1;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase   <= PH_LOW;
                        cnt     <= '0;
                        bit_idx <= '0;
                        ser_clk <= 1'b0;
                        ser_out <= load_word[DATA_W-1];
                        tx_sr   <= {load_word[DATA_W-2:0], 1'b0};
                    end
                end
                PH_LOW: begin
                    if (half_end) begin
                        phase   <= PH_HIGH;
                        cnt     <= '0;
                        ser_clk <= 1'b1;
                        rx_sr   <= {rx_sr[DATA_W-2:0], ser_in};
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (!half_end) begin
                        cnt <= cnt + 1'b1;
                    end else if (bit_idx != BIT_LAST) begin
                        phase   <= PH_LOW;
                        cnt     <= '0;
                        bit_idx <= bit_idx + 1'b1;
                        ser_clk <= 1'b0;
                        ser_out <= tx_sr[DATA_W-1];
                        tx_sr   <= {tx_sr[DATA_W-2:0], 1'b0};
                    end else if (start) begin
                        phase   <= PH_LOW;
                        cnt     <= '0;
                        bit_idx <= '0;
                        ser_clk <= 1'b0;
                        ser_out <= load_word[DATA_W-1];
                        tx_sr   <= {load_word[DATA_W-2:0], 1'b0};
                    end else begin
                        phase <= PH_IDLE;
                        cnt   <= '0;
                    end
                end
                default: begin
                    phase   <= PH_IDLE;
                    ser_clk <= 1'b1;
                end
            endcase
        end
    end

    // Registered one-cycle transmit-complete pulse
    always_ff @(posedge clk) begin
        if (!rst_n) tx_irq <= 1'b0;
        else        tx_irq <= frame_done;
    end

    AST_IDLE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> ser_clk); // R2
    AST_HIGH_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HIGH) |-> $stable(ser_out)); // R3
    AST_TXIRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq); // R5
endmodule

// File: rtl/ssm_tx_buf.sv
// One-entry transmit buffer. A host write fills it; a load into the shift
// engine empties it. A write in the same cycle as a load wins, because
// the engine takes the old word while the new one lands.
// Assumes the host writes only while the buffer is empty.
module ssm_tx_buf #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load,
    output logic [DATA_W-1:0] word,
    output logic              valid
);
    // Hold the pending word and its occupancy flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word  <= '0;
            valid <= 1'b0;
        end else if (wr_en) begin
            word  <= wr_data;
            valid <= 1'b1;
        end else if (load) begin
            valid <= 1'b0;
        end
    end

    AST_TX_LOAD_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !wr_en) |=> !valid); // R10
endmodule

// File: rtl/ssm_rx_buf.sv
// Receive buffer with a one-word hold stage. A finished frame goes straight
// to the buffer if it is empty. Otherwise the word is parked in the hold
// stage, and it moves up once the host has read the buffer.
// Assumes the flow control stops the engine while a word is held.
module ssm_rx_buf #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  logic [DATA_W-1:0] frame_word,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              pend,
    output logic              rx_irq
);
    logic [DATA_W-1:0] hold;

    // Deposit, park, promote and host-read handling for the receive side
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            hold    <= '0;
            full    <= 1'b0;
            pend    <= 1'b0;
            rx_irq  <= 1'b0;
        end else begin
            rx_irq <= 1'b0;
            if (frame_done && !full) begin
                rd_data <= frame_word;
                full    <= 1'b1;
                rx_irq  <= 1'b1;
            end else if (frame_done) begin
                hold <= frame_word;
                pend <= 1'b1;
                if (rd_en) full <= 1'b0;
            end else if (pend && !full) begin
                rd_data <= hold;
                full    <= 1'b1;
                pend    <= 1'b0;
                rx_irq  <= 1'b1;
            end else if (rd_en) begin
                full <= 1'b0;
            end
        end
    end

    AST_RX_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && full) |=> (pend && $stable(rd_data))); // R9
    AST_RXIRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq); // R4
endmodule

// File: rtl/sync_serial_master.sv
// Full-duplex synchronous serial master with host flow control.
// A frame starts or chains only when a transmit word is waiting and the
// receive side is clear, so the clock only ever stops at frame boundaries.
// With dbl_buf_en low, a frame never chains: every frame ends idle.
// Assumes dbl_buf_en changes only while idle. Reset is synchronous, active low.
module sync_serial_master #(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned CLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbl_buf_en,
    input  logic              tx_wr_en,
    input  logic [DATA_W-1:0] tx_wr_data,
    input  logic              rx_rd_en,
    output logic [DATA_W-1:0] rx_rd_data,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              tx_irq,
    output logic              rx_irq,
    output logic              ser_clk,
    output logic              ser_out,
    input  logic              ser_in
);
    logic [DATA_W-1:0] tx_word;
    logic [DATA_W-1:0] frame_word;
    logic              tx_valid;
    logic              rx_pend;
    logic              busy;
    logic              frame_done;
    logic              start;

    // Launch a frame from idle, or chain one at a frame end in double mode
    always_comb begin
        start = tx_valid && !rx_full && !rx_pend &&
                (!busy || (frame_done && dbl_buf_en));
    end

    assign tx_empty = !tx_valid;

    ssm_tx_buf #(.DATA_W(DATA_W)) u_tx_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tx_wr_en),
        .wr_data (tx_wr_data),
        .load    (start),
        .word    (tx_word),
        .valid   (tx_valid)
    );

    ssm_shift_engine #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .load_word  (tx_word),
        .ser_in     (ser_in),
        .ser_clk    (ser_clk),
        .ser_out    (ser_out),
        .rx_word    (frame_word),
        .frame_done (frame_done),
        .busy       (busy),
        .tx_irq     (tx_irq)
    );

    ssm_rx_buf #(.DATA_W(DATA_W)) u_rx_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .frame_word (frame_word),
        .rd_en      (rx_rd_en),
        .rd_data    (rx_rd_data),
        .full       (rx_full),
        .pend       (rx_pend),
        .rx_irq     (rx_irq)
    );

    AST_SINGLE_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbl_buf_en && frame_done) |=> !busy); // R6
    AST_HELD_WORD_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pend |-> ser_clk); // R8
endmodule

// File: tb/sync_serial_master_tb.sv
module sync_serial_master_tb_top;
    localparam int DW  = 8;
    localparam int DIV = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dbl = 1'b0;
    logic          wr = 1'b0;
    logic          rd = 1'b0;
    logic          ser_in = 1'b0;
    logic [DW-1:0] wdat = '0;
    logic [DW-1:0] rdat;
    logic          tx_empty, rx_full, tx_irq, rx_irq, ser_clk, ser_out;

    sync_serial_master #(.DATA_W(DW), .CLK_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .dbl_buf_en(dbl),
        .tx_wr_en(wr), .tx_wr_data(wdat), .rx_rd_en(rd), .rx_rd_data(rdat),
        .tx_empty(tx_empty), .rx_full(rx_full), .tx_irq(tx_irq), .rx_irq(rx_irq),
        .ser_clk(ser_clk), .ser_out(ser_out), .ser_in(ser_in)
    );

    always #10 clk = ~clk;

    int      total = 0;
    int      bad = 0;
    longint  cyc = 0;
    bit      armed = 1'b0;
    bit      timed_out = 1'b0;
    int      s_bits = 0;
    int      r_bits = 0;
    longint  last_fall = 0;
    longint  start_gap = 0;
    int      n_txirq = 0;
    int      n_rxirq = 0;
    int      n_wr = 0;
    int      n_rd = 0;
    logic [DW-1:0] sent [0:255];
    logic [DW-1:0] cap = '0;

    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Word the attached device returns in frame k
    function automatic logic [DW-1:0] slave_word(input int k);
        return 8'(k * 53 + 29);
    endfunction

    // Device model: drive next bit on each fall, check bit spacing (R3)
    always @(negedge ser_clk) if (armed) begin
        logic [DW-1:0] w;
        if (s_bits % DW != 0)
            chk(cyc - last_fall == DIV, "R3 fall spacing", cyc - last_fall, DIV);
        else
            start_gap = cyc - last_fall;
        w = slave_word(s_bits / DW);
        ser_in = w[DW-1 - (s_bits % DW)];
        last_fall = cyc;
        s_bits++;
    end

    // Device model: capture master data on each rise, MSB first (R3)
    always @(posedge ser_clk) if (armed) begin
        cap = {cap[DW-2:0], ser_out};
        r_bits++;
        if (r_bits % DW == 0)
            chk(cap == sent[r_bits/DW - 1], "R3 sent word", cap, sent[r_bits/DW - 1]);
    end

    always @(negedge clk) if (armed) begin
        if (tx_irq) n_txirq++;
        if (rx_irq) n_rxirq++;
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_word(input logic [DW-1:0] b);
        @(negedge clk);
        while (!tx_empty) @(negedge clk);
        wdat = b; wr = 1'b1;
        sent[n_wr] = b; n_wr++;
        @(negedge clk);
        wr = 1'b0;
        chk(tx_empty == 1'b0, "R10 empty drops after write", tx_empty, 0);
    endtask

    task automatic rd_word();
        @(negedge clk);
        while (!rx_full) @(negedge clk);
        chk(rdat == slave_word(n_rd), "R4 received word", rdat, slave_word(n_rd));
        n_rd++;
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        chk(rx_full == 1'b0, "R11 full clears after read", rx_full, 0);
    endtask

    task automatic run_main();
        void'($urandom(1234));
        idle(3);
        chk(tx_empty == 1'b1, "R1 tx_empty", tx_empty, 1);
        chk(rx_full == 1'b0, "R1 rx_full", rx_full, 0);
        chk(ser_clk == 1'b1, "R1 ser_clk", ser_clk, 1);
        chk(tx_irq == 1'b0 && rx_irq == 1'b0, "R1 irqs", tx_irq | rx_irq, 0);
        rst_n = 1'b1; armed = 1'b1;
        idle(40);
        chk(s_bits == 0, "R2 no clock without data", s_bits, 0);
        chk(ser_clk == 1'b1, "R2 clock idles high", ser_clk, 1);

        // Single-buffer mode: stop after every frame
        wr_word(8'hA5);
        @(negedge clk);
        chk(tx_empty == 1'b1, "R10 word moved to shifter", tx_empty, 1);
        while (!rx_full) @(negedge clk);
        wr_word(8'h3C);
        idle(40);
        chk(s_bits == 8, "R6 write alone does not restart", s_bits, 8);
        chk(ser_clk == 1'b1, "R6 clock high while stopped", ser_clk, 1);
        rd_word();
        rd_word();
        idle(40);
        chk(s_bits == 16, "R6 read alone does not restart", s_bits, 16);
        wr_word(8'hC3);
        rd_word();
        idle(2);
        chk(n_txirq == 3, "R5 tx_irq per frame", n_txirq, 3);

        // Double-buffer mode: back to back
        dbl = 1'b1;
        wr_word(8'h11);
        wr_word(8'h22);
        rd_word();
        rd_word();
        chk(start_gap == DIV, "R7 back-to-back join", start_gap, DIV);

        // Double-buffer mode: stall on occupied receive side
        wr_word(8'h44);
        wr_word(8'h55);
        idle(120);
        wr_word(8'h66);
        idle(60);
        chk(s_bits == 56, "R8 stalled with rx full", s_bits, 56);
        chk(ser_clk == 1'b1, "R8 clock high while stalled", ser_clk, 1);
        chk(rx_full == 1'b1, "R8 rx_full during stall", rx_full, 1);
        rd_word();
        idle(20);
        chk(s_bits == 56, "R9 still stalled while held word unread", s_bits, 56);
        chk(rx_full == 1'b1, "R9 held word promoted", rx_full, 1);
        rd_word();
        rd_word();
        idle(40);
        chk(s_bits == 64, "R8 stall on tx empty", s_bits, 64);
        chk(ser_clk == 1'b1, "R8 clock high on tx empty", ser_clk, 1);

        // Random traffic, double then single mode
        fork
            for (int i = 0; i < 60; i++) begin
                idle($urandom_range(0, 40));
                wr_word(8'($urandom));
            end
            for (int i = 0; i < 60; i++) begin
                idle($urandom_range(0, 40));
                rd_word();
            end
        join
        idle(10);
        dbl = 1'b0;
        fork
            for (int i = 0; i < 20; i++) begin
                idle($urandom_range(0, 30));
                wr_word(8'($urandom));
            end
            for (int i = 0; i < 20; i++) begin
                idle($urandom_range(0, 30));
                rd_word();
            end
        join
        idle(20);
        chk(n_txirq == s_bits / DW, "R5 tx_irq count", n_txirq, s_bits / DW);
        chk(n_rxirq == n_rd, "R9 rx_irq count", n_rxirq, n_rd);
        chk(r_bits == n_wr * DW, "R3 all words sent", r_bits, n_wr * DW);
    endtask

    initial begin
        fork
            run_main();
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        if (timed_out) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule